// File: doc/BRIEF.md
# Raster Line Point Generator

This block walks the integer grid from a start point to an end point, one point per clock, using only additions and comparisons. Coordinates are signed two's-complement words. A start pulse samples both end points. One setup cycle then computes the spans, their magnitudes, the step direction on each axis, the initial error and the two sets of increments. From then on the block presents one grid point per cycle with a valid strobe, until the registered end test reports that the end point was reached.

The end test is registered, so the controller reacts to the result of the previous step. When the flag is seen, the controller reloads the start point instead of stepping again, and then parks with a done flag until the next start pulse. The larger of the two spans is the major axis, and it advances on every point. The minor axis advances only when the running error is non-negative. The block assumes that both spans stay below 2^(W-2), so the error arithmetic cannot overflow, and that the coordinate one past the end point can still be represented.

Top module: `line_stepper`

## Requirements
- R1: During reset and afterwards, until the first start pulse, `pt_valid` and `done` are both 0.
- R2: A start pulse sampled while idle or done captures all four coordinates. The following cycle is a setup cycle. In the cycle after that, `pt_valid` is 1 and `pt_x`/`pt_y` equal the start point.
- R3: `pt_valid` is 1 for exactly N+1 consecutive cycles, where N = max(|x_to−x_from|, |y_to−y_from|), and the last point shown equals the end point.
- R4: The major axis is x when |dx| > |dy| and y otherwise, ties included. On each successive point the major coordinate changes by its step: −1 when that axis's delta is negative and +1 otherwise.
- R5: With D the minor-axis span and N > 0, the minor coordinate of point k (k = 0..N) lies min(k, floor((k+1)·D/N)) steps from its start value, in the direction of the end point.
- R6: After the last valid point, one cycle follows with both `pt_valid` and `done` at 0. `done` is 1 from the next cycle on.
- R7: While done, `done` stays at 1 and `pt_x`/`pt_y` show the sampled start point until a start pulse is accepted.
- R8: A start pulse during the setup or drawing cycles is ignored. The line in progress finishes with its originally sampled coordinates and with unchanged timing.
- R9: A line whose end point equals its start point yields exactly one valid point, then follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new line (accepted when idle or done) |
| x_from | input | W | Start x, signed |
| y_from | input | W | Start y, signed |
| x_to | input | W | End x, signed |
| y_to | input | W | End y, signed |
| pt_x | output | W | Current point x, signed |
| pt_y | output | W | Current point y, signed |
| pt_valid | output | 1 | Current point is part of the line |
| done | output | 1 | Line finished, block parked |

## Verification
Counted from the clock edge that samples `start`, point k is due in the cycle after edge k+2. The no-strobe gap falls after edge N+3, and `done` rises after edge N+4. The bench drives `start` on a falling edge and samples every output on the falling edge of each following cycle, so every comparison lands in exactly one of those numbered cycles. Expected coordinates come from the closed-form point formula of R4 and R5. They are swept over every span from −5 to +5 on both axes from several origins, and extended with long lines, a zero-length line and a start pulse injected mid-line.

// File: rtl/line_pkg.sv
// Shared types for the line point generator.
package line_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_FIRST,
        ST_LOOP,
        ST_DONE
    } ln_state_t;
endpackage

// File: rtl/line_setup.sv
// line_setup: combinational setup arithmetic for one line.
// Forms spans, magnitudes, step directions, the initial error and the two
// increment sets (used when the error is >= 0 / < 0).
// Assumes both spans are below 2**(W-2) so nothing overflows.
module line_setup #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] xa,
    input  logic signed [W-1:0] ya,
    input  logic signed [W-1:0] xb,
    input  logic signed [W-1:0] yb,
    output logic signed [W-1:0] e_init,
    output logic signed [W-1:0] einc_p,
    output logic signed [W-1:0] einc_n,
    output logic signed [W-1:0] xinc_p,
    output logic signed [W-1:0] xinc_n,
    output logic signed [W-1:0] yinc_p,
    output logic signed [W-1:0] yinc_n
);
    localparam logic signed [W-1:0] PLUS1  = W'(1);
    localparam logic signed [W-1:0] MINUS1 = {W{1'b1}};
    localparam logic signed [W-1:0] ZERO   = '0;

    logic signed [W-1:0] dx, dy, adx, ady, sx, sy;
    logic                x_major;

    // Purpose: derive per-line constants from the sampled end points.
    always_comb begin
        dx      = xb - xa;
        dy      = yb - ya;
        adx     = dx[W-1] ? -dx : dx;
        ady     = dy[W-1] ? -dy : dy;
        sx      = dx[W-1] ? MINUS1 : PLUS1;
        sy      = dy[W-1] ? MINUS1 : PLUS1;
        x_major = adx > ady;
        if (x_major) begin
            e_init = (ady + ady) - adx;
            einc_p = ady - adx;
            einc_n = ady;
            xinc_p = sx;
            xinc_n = sx;
            yinc_p = sy;
            yinc_n = ZERO;
        end else begin
            e_init = (adx + adx) - ady;
            einc_p = adx - ady;
            einc_n = adx;
            xinc_p = sx;
            xinc_n = ZERO;
            yinc_p = sy;
            yinc_n = sy;
        end
    end
endmodule

// File: rtl/line_ctrl.sv
// line_ctrl: sequencing FSM. idle -> setup -> first step -> repeated steps
// until the registered end flag is seen -> reload and park in done.
// Assumes eol comes from a register updated on step cycles only.
module line_ctrl
    import line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic eol,
    output logic cap,
    output logic ld,
    output logic step,
    output logic pt_valid,
    output logic done
);
    ln_state_t state, state_nx;

    // Purpose: next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_INIT;
            ST_INIT:  state_nx = ST_FIRST;
            ST_FIRST: state_nx = ST_LOOP;
            ST_LOOP:  if (eol) state_nx = ST_DONE;
            ST_DONE:  if (start) state_nx = ST_INIT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: datapath commands and outputs decoded from the state.
    always_comb begin
        cap      = start && (state == ST_IDLE || state == ST_DONE);
        ld       = (state == ST_INIT) || (state == ST_DONE) ||
                   (state == ST_LOOP && eol);
        step     = (state == ST_FIRST) || (state == ST_LOOP && !eol);
        pt_valid = step;
        done     = (state == ST_DONE);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pt_valid && !done));

    assert_end_to_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP && eol) |=> (state == ST_DONE));

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state == ST_INIT || state == ST_FIRST || state == ST_LOOP))
        |=> (state != ST_INIT));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pt_valid && done));
endmodule

// File: rtl/line_core.sv
// line_core: coordinate, error and increment registers plus the end flag.
// Captures end points on cap, reloads setup values on ld, steps on step.
// Assumes cap/ld/step come from line_ctrl; ld and step never coincide.
module line_core #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic                ld,
    input  logic                step,
    input  logic signed [W-1:0] x_from,
    input  logic signed [W-1:0] y_from,
    input  logic signed [W-1:0] x_to,
    input  logic signed [W-1:0] y_to,
    output logic signed [W-1:0] pt_x,
    output logic signed [W-1:0] pt_y,
    output logic                eol
);
    logic signed [W-1:0] xa, ya, xb, yb;
    logic signed [W-1:0] cx, cy, ce;
    logic signed [W-1:0] r_einc_p, r_einc_n, r_xinc_p, r_xinc_n, r_yinc_p, r_yinc_n;
    logic signed [W-1:0] s_e, s_einc_p, s_einc_n, s_xinc_p, s_xinc_n, s_yinc_p, s_yinc_n;

    line_setup #(.W(W)) u_setup (
        .xa(xa), .ya(ya), .xb(xb), .yb(yb),
        .e_init(s_e),
        .einc_p(s_einc_p), .einc_n(s_einc_n),
        .xinc_p(s_xinc_p), .xinc_n(s_xinc_n),
        .yinc_p(s_yinc_p), .yinc_n(s_yinc_n)
    );

    // Purpose: hold the end points sampled at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa <= '0; ya <= '0; xb <= '0; yb <= '0;
        end else if (cap) begin
            xa <= x_from; ya <= y_from; xb <= x_to; yb <= y_to;
        end
    end

    // Purpose: load setup values or take one grid step with end test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cx <= '0; cy <= '0; ce <= '0; eol <= 1'b0;
            r_einc_p <= '0; r_einc_n <= '0;
            r_xinc_p <= '0; r_xinc_n <= '0;
            r_yinc_p <= '0; r_yinc_n <= '0;
        end else if (ld) begin
            cx <= xa; cy <= ya; ce <= s_e; eol <= 1'b0;
            r_einc_p <= s_einc_p; r_einc_n <= s_einc_n;
            r_xinc_p <= s_xinc_p; r_xinc_n <= s_xinc_n;
            r_yinc_p <= s_yinc_p; r_yinc_n <= s_yinc_n;
        end else if (step) begin
            eol <= (cx == xb) && (cy == yb);
            if (!ce[W-1]) begin
                cx <= cx + r_xinc_p; cy <= cy + r_yinc_p; ce <= ce + r_einc_p;
            end else begin
                cx <= cx + r_xinc_n; cy <= cy + r_yinc_n; ce <= ce + r_einc_n;
            end
        end
    end

    assign pt_x = cx;
    assign pt_y = cy;

    assert_unit_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((cx == $past(cx)) || (cx == $past(cx) + 1'sb1) || (cx == $past(cx) - 1'sb1)) &&
                 ((cy == $past(cy)) || (cy == $past(cy) + 1'sb1) || (cy == $past(cy) - 1'sb1)));
endmodule

// File: rtl/line_stepper.sv
// line_stepper: top of the raster line point generator.
// Emits one grid point per clock from start to end, then parks in done.
// Assumes spans below 2**(W-2); start is honoured only when idle or done.
module line_stepper #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] x_from,
    input  logic signed [W-1:0] y_from,
    input  logic signed [W-1:0] x_to,
    input  logic signed [W-1:0] y_to,
    output logic signed [W-1:0] pt_x,
    output logic signed [W-1:0] pt_y,
    output logic                pt_valid,
    output logic                done
);
    logic cap, ld, step, eol;

    line_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .eol(eol),
        .cap(cap), .ld(ld), .step(step), .pt_valid(pt_valid), .done(done)
    );

    line_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .cap(cap), .ld(ld), .step(step),
        .x_from(x_from), .y_from(y_from), .x_to(x_to), .y_to(y_to),
        .pt_x(pt_x), .pt_y(pt_y), .eol(eol)
    );

    assert_done_holds_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(pt_x) && $stable(pt_y)));
endmodule

// File: tb/line_stepper_bench.sv
module line_stepper_bench;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0] x_from = '0, y_from = '0, x_to = '0, y_to = '0;
    logic signed [W-1:0] pt_x, pt_y;
    logic pt_valid, done;

    int n_chk = 0;
    int n_fail = 0;

    line_stepper #(.W(W)) u_line_stepper (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_from(x_from), .y_from(y_from), .x_to(x_to), .y_to(y_to),
        .pt_x(pt_x), .pt_y(pt_y), .pt_valid(pt_valid), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Draw one line and compare every cycle against the closed-form points.
    task automatic run_line(input int x1, input int y1, input int x2, input int y2,
                            input bit poke);
        int adx = iabs(x2 - x1);
        int ady = iabs(y2 - y1);
        int sx = (x2 - x1 < 0) ? -1 : 1;
        int sy = (y2 - y1 < 0) ? -1 : 1;
        bit xmaj = adx > ady;
        int n = xmaj ? adx : ady;
        int d = xmaj ? ady : adx;
        @(negedge clk);
        x_from = W'(x1); y_from = W'(y1); x_to = W'(x2); y_to = W'(y2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= n + 3; c++) begin
            @(negedge clk);
            if (c <= n + 1) begin
                int k = c - 1;
                int moff = (n == 0) ? 0 : (((k + 1) * d) / n < k ? ((k + 1) * d) / n : k);
                int ex = xmaj ? x1 + k * sx : x1 + moff * sx;
                int ey = xmaj ? y1 + moff * sy : y1 + k * sy;
                string rq = (k == 0) ? "R2" : ((n == 0) ? "R9" : "R3");
                check(pt_valid == 1'b1, rq, "pt_valid in point cycle", int'(pt_valid), 1);
                check(int'(xmaj ? pt_x : pt_y) == (xmaj ? ex : ey), (k == 0) ? "R2" : "R4",
                      "major coordinate", int'(xmaj ? pt_x : pt_y), xmaj ? ex : ey);
                check(int'(xmaj ? pt_y : pt_x) == (xmaj ? ey : ex), (k == 0) ? "R2" : "R5",
                      "minor coordinate", int'(xmaj ? pt_y : pt_x), xmaj ? ey : ex);
                if (k == n) begin
                    check(int'(pt_x) == x2 && int'(pt_y) == y2, "R3", "last point x",
                          int'(pt_x), x2);
                end
            end else if (c == n + 2) begin
                check(!pt_valid && !done, (n == 0) ? "R9" : "R6", "gap cycle valid+done",
                      int'(pt_valid) + int'(done), 0);
            end else begin
                check(done == 1'b1, "R6", "done after gap", int'(done), 1);
                check(int'(pt_x) == x1, "R7", "parked x", int'(pt_x), x1);
                check(int'(pt_y) == y1, "R7", "parked y", int'(pt_y), y1);
            end
            if (poke && c == 2) begin
                x_from = W'(x1 + 7); y_from = W'(y1 - 3); x_to = W'(x2 - 9); y_to = W'(y2 + 5);
                start = 1'b1;
            end
            if (poke && c == 3) start = 1'b0;
        end
        @(negedge clk);
        check(done == 1'b1 && int'(pt_x) == x1 && int'(pt_y) == y1, poke ? "R8" : "R7",
              "still parked (x)", int'(pt_x), x1);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs quiet during and after reset
        repeat (3) @(negedge clk);
        check(!pt_valid && !done, "R1", "in reset", int'(pt_valid) + int'(done), 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!pt_valid && !done, "R1", "idle after reset", int'(pt_valid) + int'(done), 0);
        end
        // Reference line, then a zero-length line (R9)
        run_line(5, 2, 18, 8, 1'b0);
        run_line(3, 3, 3, 3, 1'b0);
        // Near-exhaustive sweep of spans from several origins
        for (int o = 0; o < 3; o++) begin
            int ox = (o == 0) ? 0 : ((o == 1) ? -30 : 100);
            int oy = (o == 0) ? 0 : ((o == 1) ? -7 : -250);
            for (int ddx = -5; ddx <= 5; ddx++) begin
                for (int ddy = -5; ddy <= 5; ddy++) begin
                    run_line(ox, oy, ox + ddx, oy + ddy, 1'b0);
                end
            end
        end
        // Long lines and a start pulse injected mid-line (R8)
        run_line(-40, 30, 60, -17, 1'b0);
        run_line(12, -90, -5, 110, 1'b0);
        run_line(0, 0, 9, -4, 1'b1);
        run_line(-8, 6, -8, -14, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule